// File: doc/BRIEF.md
# Processor Status Register and Flag Update Unit

This block holds the eight-bit status word of a small processor core: a global interrupt-enable bit, a bit-transfer flag and six arithmetic condition codes. Each cycle the execute stage may present one flag operation. It gives an operation class, the two ALU operands and the ALU result, and for the bit-oriented classes a bit selector. The unit derives the condition codes from these values and rewrites only the bits owned by that class. All other bits keep their value.

The same register is also a memory-mapped location. A simple bus port reaches it at one address in the I/O space and at an alias in the data space. Software can therefore save, restore or clear the whole word with a single store. Storing zero clears the interrupt-enable and transfer bits as well as the condition codes. The ALU datapath, the instruction decoder and interrupt dispatch live elsewhere.

Top module: `status_reg_unit`

## Requirements
- R1: An active-low reset clears all eight status bits to 0x00.
- R2: The status word is ordered, from bit 7 to bit 0, as interrupt-enable I, transfer T, half-carry H, sign S, overflow V, negative N, zero Z, carry C; the `status` port and the bus read return this word.
- R3: Subtract (op_class 1) and compare (op_class 2) write C = unsigned borrow (a < b), H = borrow out of the low nibble, V = signed overflow of a - b, N = result bit 7, Z = result all zeros, S = N xor V, and leave I and T unchanged.
- R4: Add (op_class 3) writes C = carry out of bit 7, H = carry out of bit 3, V = signed overflow of a + b, N, Z and S as in R3, and leaves I and T unchanged.
- R5: Logical AND (op_class 4) and OR (op_class 5) clear V, set N and Z from the result and S = N xor V, and leave C, H, I and T unchanged.
- R6: Bit-store (op_class 6) copies operand-a bit `flag_sel` into T and changes no other bit.
- R7: Flag set (op_class 7) and flag clear (op_class 8) force status bit `flag_sel[2:0]` to 1 or 0 and change no other bit.
- R8: A bus write with bus_space=1 at address 0x003F, or with bus_space=0 at address 0x005F, replaces all eight bits with bus_wdata; a write to any other space/address pair has no effect.
- R9: When a bus write to the register and a flag operation fall in the same cycle, the register takes the bus data.
- R10: bus_hit is high and bus_rdata equals the current (pre-update) register value whenever the bus addresses the register; otherwise bus_hit is low and bus_rdata is 0x00.
- R11: Comparing a value with itself yields Z=1 with C, H, V, N and S clear; subtracting zero from a positive non-zero value clears all six condition codes.
- R12: With op_valid low (or op_class 0) and no bus write to the register, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A flag operation is presented this cycle |
| op_class | input | 4 | Operation class code |
| flag_sel | input | SEL_W (3) | Operand bit for bit-store; status bit for set/clear |
| opnd_a | input | DATA_W (8) | First ALU operand (minuend / addend) |
| opnd_b | input | DATA_W (8) | Second ALU operand (subtrahend / addend) |
| alu_res | input | DATA_W (8) | ALU result for this operation |
| bus_space | input | 1 | 1 = I/O space, 0 = data space |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational |
| bus_hit | output | 1 | The bus addresses the status register |
| status | output | 8 | Current status word |

## Verification
Every flag update lands in the register one clock after the operation is presented, so a wrong mask or a wrong flag equation shows on `status` in the cycle after the stimulus. It persists there until the next write to that bit. The bench first loads a known pattern through the bus, which makes bits that should have been kept directly visible. A wrong address decode shows at once on `bus_hit` and `bus_rdata`, in the same cycle, before any clock edge.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;

   localparam int SR_W = 8;

   // status bit positions (fixed layout, decoded by neighbours)
   localparam int B_C = 0;
   localparam int B_Z = 1;
   localparam int B_N = 2;
   localparam int B_V = 3;
   localparam int B_S = 4;
   localparam int B_H = 5;
   localparam int B_T = 6;
   localparam int B_I = 7;

   localparam logic [SR_W-1:0] CC_MASK    = 8'h3F;
   localparam logic [SR_W-1:0] LOGIC_MASK = 8'h1E;

   typedef enum logic [3:0] {
      OP_NONE = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_ADD  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_BST  = 4'd6,
      OP_BSET = 4'd7,
      OP_BCLR = 4'd8
   } op_e;

   typedef struct packed {
      logic h;
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } cc_t;

endpackage

// File: rtl/sreg_arith_flags.sv
module sreg_arith_flags
   import status_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int MSB   = DATA_W - 1,
   localparam int NIB   = 3
) (
   input  logic              is_add,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] r,
   output cc_t               cc
);

   logic am, bm, rm, an, bn, rn;
   logic carry, half, ovf;

   assign am = a[MSB];
   assign bm = b[MSB];
   assign rm = r[MSB];
   assign an = a[NIB];
   assign bn = b[NIB];
   assign rn = r[NIB];

   always_comb begin
      if (is_add) begin
         carry = (am & bm) | (bm & ~rm) | (~rm & am);
         half  = (an & bn) | (bn & ~rn) | (~rn & an);
         ovf   = (am & bm & ~rm) | (~am & ~bm & rm);
      end else begin
         carry = (~am & bm) | (bm & rm) | (rm & ~am);
         half  = (~an & bn) | (bn & rn) | (rn & ~an);
         ovf   = (am & ~bm & ~rm) | (~am & bm & rm);
      end
   end

   always_comb begin
      cc.c = carry;
      cc.h = half;
      cc.v = ovf;
      cc.n = rm;
      cc.z = (r == '0);
      cc.s = rm ^ ovf;
   end

endmodule

// File: rtl/sreg_logic_flags.sv
module sreg_logic_flags
   import status_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] r,
   output logic              n,
   output logic              z,
   output logic              v,
   output logic              s
);

   assign n = r[DATA_W-1];
   assign z = (r == '0);
   assign v = 1'b0;
   assign s = r[DATA_W-1] ^ 1'b0;

endmodule

// File: rtl/sreg_update_sel.sv
module sreg_update_sel
   import status_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
) (
   input  logic              op_valid,
   input  logic [3:0]        op_class,
   input  logic [SEL_W-1:0]  flag_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  cc_t               arith_cc,
   input  logic              lg_n,
   input  logic              lg_z,
   input  logic              lg_v,
   input  logic              lg_s,
   output logic [SR_W-1:0]   upd_mask,
   output logic [SR_W-1:0]   upd_val
);

   logic [2:0] bidx;
   assign bidx = flag_sel[2:0];

   always_comb begin
      upd_mask = '0;
      upd_val  = '0;
      case (op_e'(op_class))
         OP_SUB, OP_CMP, OP_ADD: begin
            upd_mask     = CC_MASK;
            upd_val[B_C] = arith_cc.c;
            upd_val[B_Z] = arith_cc.z;
            upd_val[B_N] = arith_cc.n;
            upd_val[B_V] = arith_cc.v;
            upd_val[B_S] = arith_cc.s;
            upd_val[B_H] = arith_cc.h;
         end
         OP_AND, OP_OR: begin
            upd_mask     = LOGIC_MASK;
            upd_val[B_Z] = lg_z;
            upd_val[B_N] = lg_n;
            upd_val[B_V] = lg_v;
            upd_val[B_S] = lg_s;
         end
         OP_BST: begin
            upd_mask[B_T] = 1'b1;
            upd_val[B_T]  = opnd_a[flag_sel];
         end
         OP_BSET: begin
            upd_mask[bidx] = 1'b1;
            upd_val[bidx]  = 1'b1;
         end
         OP_BCLR: begin
            upd_mask[bidx] = 1'b1;
            upd_val[bidx]  = 1'b0;
         end
         default: begin
            upd_mask = '0;
         end
      endcase
      if (!op_valid) upd_mask = '0;
   end

endmodule

// File: rtl/sreg_bus_port.sv
module sreg_bus_port
   import status_flag_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] IO_ADDR  = 16'h003F,
   parameter logic [ADDR_W-1:0] DS_ADDR  = 16'h005F
) (
   input  logic              bus_space,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [SR_W-1:0]   cur,
   output logic              hit,
   output logic              wr_take,
   output logic [SR_W-1:0]   rdata
);

   logic io_hit, ds_hit;

   assign io_hit  = bus_space & (bus_addr == IO_ADDR);
   assign ds_hit  = ~bus_space & (bus_addr == DS_ADDR);
   assign hit     = io_hit | ds_hit;
   assign wr_take = hit & bus_we;
   assign rdata   = hit ? cur : '0;

endmodule

// File: rtl/status_reg_unit.sv
module status_reg_unit
   import status_flag_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] IO_ADDR = 16'h003F,
   parameter logic [ADDR_W-1:0] DS_ADDR = 16'h005F,
   localparam int               SEL_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_class,
   input  logic [SEL_W-1:0]  flag_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              bus_space,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              bus_hit,
   output logic [7:0]        status
);

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("status_reg_unit: DATA_W must be at least 8");
   end
   if (IO_ADDR == DS_ADDR) begin : g_bad_alias
      $error("status_reg_unit: I/O and data-space addresses must differ");
   end

   logic [SR_W-1:0] sreg_q, sreg_d;
   logic [SR_W-1:0] upd_mask, upd_val;
   logic            wr_take;
   logic            is_add;
   cc_t             arith_cc;
   logic            lg_n, lg_z, lg_v, lg_s;

   assign is_add = (op_e'(op_class) == OP_ADD);

   sreg_arith_flags #(.DATA_W(DATA_W)) u_arith (
      .is_add (is_add),
      .a      (opnd_a),
      .b      (opnd_b),
      .r      (alu_res),
      .cc     (arith_cc)
   );

   sreg_logic_flags #(.DATA_W(DATA_W)) u_logic (
      .r (alu_res),
      .n (lg_n),
      .z (lg_z),
      .v (lg_v),
      .s (lg_s)
   );

   sreg_update_sel #(.DATA_W(DATA_W)) u_sel (
      .op_valid (op_valid),
      .op_class (op_class),
      .flag_sel (flag_sel),
      .opnd_a   (opnd_a),
      .arith_cc (arith_cc),
      .lg_n     (lg_n),
      .lg_z     (lg_z),
      .lg_v     (lg_v),
      .lg_s     (lg_s),
      .upd_mask (upd_mask),
      .upd_val  (upd_val)
   );

   sreg_bus_port #(
      .ADDR_W  (ADDR_W),
      .IO_ADDR (IO_ADDR),
      .DS_ADDR (DS_ADDR)
   ) u_bus (
      .bus_space (bus_space),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .cur       (sreg_q),
      .hit       (bus_hit),
      .wr_take   (wr_take),
      .rdata     (bus_rdata)
   );

   // per-bit next-state: bus write first, then class update, else hold
   for (genvar gi = 0; gi < SR_W; gi++) begin : g_bit
      logic nb;
      assign nb = wr_take      ? bus_wdata[gi] :
                  upd_mask[gi] ? upd_val[gi]   : sreg_q[gi];
      assign sreg_d[gi] = nb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sreg_q <= '0;
      else        sreg_q <= sreg_d;
   end

   assign status = sreg_q;

endmodule

// File: rtl/status_reg_unit_chk.sv
module status_reg_unit_chk
   import status_flag_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [3:0] op_class,
   input logic       bus_we,
   input logic       bus_hit,
   input logic [7:0] bus_wdata,
   input logic [7:0] status
);

   logic bus_wr, arith_op, logic_op, bst_op, bset_op, idle;

   assign bus_wr   = bus_we & bus_hit;
   assign arith_op = op_valid & ~bus_wr &
                     ((op_class == OP_SUB) | (op_class == OP_CMP) | (op_class == OP_ADD));
   assign logic_op = op_valid & ~bus_wr & ((op_class == OP_AND) | (op_class == OP_OR));
   assign bst_op   = op_valid & ~bus_wr & (op_class == OP_BST);
   assign bset_op  = op_valid & ~bus_wr & ((op_class == OP_BSET) | (op_class == OP_BCLR));
   assign idle     = ~bus_wr & (~op_valid | (op_class == OP_NONE));

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> status == 8'h00);

   assert_bus_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> status == $past(bus_wdata));

   assert_arith_keeps_it_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arith_op |=> status[7:6] == $past(status[7:6]));

   assert_arith_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      arith_op |=> status[B_S] == (status[B_N] ^ status[B_V]));

   assert_logic_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      logic_op |=> (status[B_V] == 1'b0) &&
                   (status[B_C] == $past(status[B_C])) &&
                   (status[7:5] == $past(status[7:5])));

   assert_bst_only_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bst_op |=> (status[7] == $past(status[7])) && (status[5:0] == $past(status[5:0])));

   assert_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bset_op |=> $countones(status ^ $past(status)) <= 1);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> $stable(status));

endmodule

bind status_reg_unit status_reg_unit_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_class  (op_class),
   .bus_we    (bus_we),
   .bus_hit   (bus_hit),
   .bus_wdata (bus_wdata),
   .status    (status)
);

// File: tb/status_reg_unit_bench.sv
module status_reg_unit_bench;
   import status_flag_pkg::*;

   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_class = 4'd0;
   logic [2:0]  flag_sel = 3'd0;
   logic [7:0]  opnd_a = 8'h00, opnd_b = 8'h00, alu_res = 8'h00;
   logic        bus_space = 1'b1;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata, status;
   logic        bus_hit;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   status_reg_unit u_status_reg_unit (
      .clk, .rst_n, .op_valid, .op_class, .flag_sel, .opnd_a, .opnd_b,
      .alu_res, .bus_space, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
      .bus_hit, .status
   );

   // {op, idx, a, b, preload}
   localparam logic [31:0] VEC [16] = '{
      32'h10503000, 32'h103050C0, 32'h10800100, 32'h1010013F,
      32'h207F7FFF, 32'h1005003F, 32'h307F0100, 32'h30FF0140,
      32'h30080800, 32'h40F00F21, 32'h5080013F, 32'h67800000,
      32'h60FE00FF, 32'h77000000, 32'h810000FF, 32'h86000040
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
      case (op)
         4'd1, 4'd2: return a - b;
         4'd3:       return a + b;
         4'd4:       return a & b;
         4'd5:       return a | b;
         default:    return 8'h00;
      endcase
   endfunction

   // expected status from the requirement text
   function automatic logic [7:0] model(input logic [3:0] op, input logic [2:0] idx,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] pre);
      logic [7:0] r, e;
      int sa, sb, sd;
      r = alu(op, a, b);
      e = pre;
      sa = int'($signed(a));
      sb = int'($signed(b));
      case (op)
         4'd1, 4'd2: begin
            sd = sa - sb;
            e[0] = a < b;
            e[5] = a[3:0] < b[3:0];
            e[3] = (sd > 127) || (sd < -128);
         end
         4'd3: begin
            sd = sa + sb;
            e[0] = (int'(a) + int'(b)) > 255;
            e[5] = (int'(a[3:0]) + int'(b[3:0])) > 15;
            e[3] = (sd > 127) || (sd < -128);
         end
         4'd4, 4'd5: e[3] = 1'b0;
         4'd6: e[6] = a[idx];
         4'd7: e[idx] = 1'b1;
         4'd8: e[idx] = 1'b0;
         default: ;
      endcase
      if (op >= 4'd1 && op <= 4'd5) begin
         e[2] = r[7];
         e[1] = (r == 8'h00);
         e[4] = e[2] ^ e[3];
      end
      return e;
   endfunction

   function automatic string tag(input logic [3:0] op);
      case (op)
         4'd1, 4'd2: return "R3";
         4'd3:       return "R4";
         4'd4, 4'd5: return "R5";
         4'd6:       return "R6 R2";
         default:    return "R7 R2";
      endcase
   endfunction

   task automatic bus_write(input logic sp, input logic [15:0] ad, input logic [7:0] d);
      @(negedge clk);
      op_valid = 1'b0;
      bus_space = sp; bus_addr = ad; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic drive_op(input logic [3:0] op, input logic [2:0] idx,
                           input logic [7:0] a, input logic [7:0] b);
      op_class = op; flag_sel = idx; opnd_a = a; opnd_b = b;
      alu_res = alu(op, a, b);
      op_valid = 1'b1;
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset value
      repeat (3) @(negedge clk);
      check("R1 during reset", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", status, 8'h00);

      // table walk
      foreach (VEC[i]) begin
         logic [3:0] op;
         logic [2:0] idx;
         logic [7:0] a, b, pre;
         {op, idx, a, b, pre} = {VEC[i][31:28], VEC[i][26:24], VEC[i][23:16],
                                 VEC[i][15:8], VEC[i][7:0]};
         bus_write(1'b1, 16'h003F, pre);
         drive_op(op, idx, a, b);
         @(negedge clk);
         op_valid = 1'b0;
         check(tag(op), status, model(op, idx, a, b, pre));
      end

      // R11: compare with itself, subtract zero from positive value
      bus_write(1'b1, 16'h003F, 8'hFF);
      drive_op(4'd2, 3'd0, 8'h33, 8'h33);
      @(negedge clk); op_valid = 1'b0;
      check("R11 cmp self", status, 8'hC2);
      bus_write(1'b1, 16'h003F, 8'h3F);
      drive_op(4'd1, 3'd0, 8'h01, 8'h00);
      @(negedge clk); op_valid = 1'b0;
      check("R11 sub zero", status, 8'h00);

      // R8: data-space alias, zero write clears I and T, wrong pair ignored
      bus_write(1'b0, 16'h005F, 8'hA5);
      check("R8 alias write", status, 8'hA5);
      bus_write(1'b1, 16'h003F, 8'hC0);
      bus_write(1'b1, 16'h003F, 8'h00);
      check("R8 zero clears I T", status, 8'h00);
      bus_write(1'b0, 16'h003F, 8'hFF);
      check("R8 wrong space ignored", status, 8'h00);
      bus_write(1'b1, 16'h005F, 8'hFF);
      check("R8 wrong space alias ignored", status, 8'h00);

      // R9: bus write wins over flag op
      @(negedge clk);
      drive_op(4'd7, 3'd1, 8'h00, 8'h00);
      bus_space = 1'b1; bus_addr = 16'h003F; bus_wdata = 8'h81; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; op_valid = 1'b0;
      check("R9 bus wins", status, 8'h81);

      // R10: read returns pre-update value, miss returns zero
      drive_op(4'd8, 3'd7, 8'h00, 8'h00);
      bus_space = 1'b1; bus_addr = 16'h003F;
      #1;
      check("R10 hit", {7'd0, bus_hit}, 8'h01);
      check("R10 pre-update read", bus_rdata, 8'h81);
      @(negedge clk);
      op_valid = 1'b0;
      check("R10 after update", status, 8'h01);
      check("R10 read follows", bus_rdata, 8'h01);
      bus_addr = 16'h0020;
      #1;
      check("R10 miss hit", {7'd0, bus_hit}, 8'h00);
      check("R10 miss data", bus_rdata, 8'h00);

      // R12: op_valid low, and class 0 while valid
      bus_write(1'b1, 16'h003F, 8'h5A);
      op_class = 4'd1; opnd_a = 8'h00; opnd_b = 8'h01; alu_res = 8'hFF; op_valid = 1'b0;
      @(negedge clk);
      check("R12 invalid op held", status, 8'h5A);
      drive_op(4'd0, 3'd0, 8'h00, 8'h01);
      @(negedge clk); op_valid = 1'b0;
      check("R12 class none held", status, 8'h5A);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule